// File: doc/BRIEF.md
# Table-Driven Bit-Plane Weight Dequantizer

This block takes quantized weights that arrive as bit-planes and turns each group of weights into dequantized fixed-point values. It uses only table lookups and does this in two steps. A group holds GROUP weights, and each weight has an NPLANES-bit code. For every plane, a word carries one GROUP-bit slice that holds that plane's bit of each weight. A fixed unpacking table maps each slice to one field per element. The fields are weighted by their plane index and added together, which rebuilds each element's integer code.

A conversion table then maps each code to its dequantized value. Software loads this table before use with scale·(q − zero_point). No multiplier or subtractor appears on the data path, so changing the scale or zero point only means reloading 2^NPLANES words.

Groups enter and leave on valid/ready handshakes, and the block accepts one group per cycle. The conversion table has its own write port, with a ready signal that blocks writes while any group is inside the block. A pending write also blocks new groups, so the pipeline drains and the write can complete.

Top module: `twolvl_dequant`

## Requirements
- R1: After reset, out_valid is 0, and tbl_ready is 1. With tbl_we low, in_ready is 1.
- R2: Bit b·GROUP + j of in_planes is plane b of element j. The element's code is q_j = Σ_b bit(b,j)·2^b, with plane 0 as the least significant bit.
- R3: Output lane j sits at out_data[j·DW +: DW] and equals the conversion table entry at index q_j for the group.
- R4: A cycle with tbl_we and tbl_ready both high writes tbl_data to conversion entry tbl_addr. Every group accepted after that cycle uses the new value.
- R5: A group accepted at clock edge k shows out_valid after edge k+1. With out_ready held high, one group per cycle passes with no bubbles.
- R6: While out_valid is high and out_ready is low, out_valid and out_data hold their values and in_ready is low.
- R7: tbl_ready is low while any accepted group has not yet completed its output handshake. A tbl_we raised in that window changes no table entry.
- R8: While tbl_we is high, in_ready is low. The pipeline therefore drains and the write completes.
- R9: Groups leave in the order they were accepted, with none lost or repeated, under any pattern of input gaps and output stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Conversion table write request |
| tbl_addr | input | NPLANES | Conversion entry index |
| tbl_data | input | DW | Conversion entry value |
| tbl_ready | output | 1 | Write accepted when high with tbl_we |
| in_valid | input | 1 | Plane-slice group present |
| in_ready | output | 1 | Block accepts a group |
| in_planes | input | NPLANES·GROUP | Plane slices, plane b at bits [b·GROUP +: GROUP] |
| out_valid | output | 1 | Dequantized group present |
| out_ready | input | 1 | Consumer accepts the group |
| out_data | output | GROUP·DW | Dequantized lanes, lane j at [j·DW +: DW] |

## Verification
The bench covers all 65536 slice patterns in order, so every code value appears in every lane. A design that swapped the plane weighting or the lane order would then give wrong words for most patterns. A second pass uses a different table together with random input gaps and output stalls. In that pass, a pipeline that dropped, repeated or reordered groups, or let out_data move during a stall, would fail on the comparison of the output sequence. Table writes are raised while a group is held in the output register and also while the pipeline drains. A block that accepted a write in flight would return the poisoned entry, and one that kept accepting groups under a pending write would never raise tbl_ready.

// File: rtl/lutdq_pkg.sv
package lutdq_pkg;

  // Contents of the first-level table: entry idx gives element j a one-bit
  // field equal to bit j of the slice.
  function automatic logic [31:0] repack_entry(input int idx);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < 32; j++) begin
      r[j] = ((idx >> j) & 1) != 0;
    end
    return r;
  endfunction

endpackage

// File: rtl/lutdq_repack_rom.sv
module lutdq_repack_rom #(
  parameter int GROUP = 4
) (
  input  logic [GROUP-1:0] slice,
  output logic [GROUP-1:0] fields
);
  localparam int DEPTH = 1 << GROUP;

  logic [GROUP-1:0] rom [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    logic [31:0] ent;
    assign ent    = lutdq_pkg::repack_entry(e);
    assign rom[e] = ent[GROUP-1:0];
  end

  assign fields = rom[slice];
endmodule

// File: rtl/lutdq_rebuild.sv
module lutdq_rebuild #(
  parameter int NPLANES = 4,
  parameter int GROUP   = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       adv,
  input  logic                       in_fire,
  input  logic [NPLANES*GROUP-1:0]   in_planes,
  output logic                       s1_valid,
  output logic [NPLANES*GROUP-1:0]   s1_codes
);
  logic [GROUP-1:0]   fld   [NPLANES];
  logic [NPLANES-1:0] codes [GROUP];

  for (genvar b = 0; b < NPLANES; b++) begin : g_plane
    lutdq_repack_rom #(.GROUP(GROUP)) u_rom (
      .slice  (in_planes[b*GROUP +: GROUP]),
      .fields (fld[b])
    );
  end

  // Shift each plane's field by its plane index and add.
  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      codes[j] = '0;
      for (int b = 0; b < NPLANES; b++) begin
        codes[j] = codes[j] + (NPLANES'(fld[b][j]) << b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_fire;
    end
  end

  always_ff @(posedge clk) begin
    if (adv && in_fire) begin
      for (int j = 0; j < GROUP; j++) begin
        s1_codes[j*NPLANES +: NPLANES] <= codes[j];
      end
    end
  end
endmodule

// File: rtl/lutdq_conv_lane.sv
module lutdq_conv_lane #(
  parameter int QW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [QW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [QW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << QW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lutdq_flow.sv
module lutdq_flow (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  input  logic tbl_we,
  input  logic s1_valid,
  output logic in_ready,
  output logic adv,
  output logic in_fire,
  output logic tbl_ready,
  output logic wr_en,
  output logic out_valid
);
  logic stall;

  assign stall     = out_valid & ~out_ready;
  assign adv       = ~stall;
  assign in_ready  = adv & ~tbl_we;
  assign in_fire   = in_valid & in_ready;
  assign tbl_ready = ~(s1_valid | out_valid);
  assign wr_en     = tbl_we & tbl_ready;

  always_ff @(posedge clk) begin
    if (rst)      out_valid <= 1'b0;
    else if (adv) out_valid <= s1_valid;
  end
endmodule

// File: rtl/twolvl_dequant.sv
module twolvl_dequant #(
  parameter int NPLANES = 4,
  parameter int GROUP   = 4,
  parameter int DW      = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tbl_we,
  input  logic [NPLANES-1:0]       tbl_addr,
  input  logic [DW-1:0]            tbl_data,
  output logic                     tbl_ready,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NPLANES*GROUP-1:0] in_planes,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [GROUP*DW-1:0]      out_data
);
  logic                     adv, in_fire, wr_en, s1_valid;
  logic [NPLANES*GROUP-1:0] s1_codes;

  lutdq_flow u_flow (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .tbl_we    (tbl_we),
    .s1_valid  (s1_valid),
    .in_ready  (in_ready),
    .adv       (adv),
    .in_fire   (in_fire),
    .tbl_ready (tbl_ready),
    .wr_en     (wr_en),
    .out_valid (out_valid)
  );

  lutdq_rebuild #(.NPLANES(NPLANES), .GROUP(GROUP)) u_rebuild (
    .clk       (clk),
    .rst       (rst),
    .adv       (adv),
    .in_fire   (in_fire),
    .in_planes (in_planes),
    .s1_valid  (s1_valid),
    .s1_codes  (s1_codes)
  );

  // One copy of the conversion table per lane, so all lanes read at once.
  for (genvar j = 0; j < GROUP; j++) begin : g_lane
    lutdq_conv_lane #(.QW(NPLANES), .DW(DW)) u_lane (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (tbl_addr),
      .wr_data (tbl_data),
      .rd_en   (adv & s1_valid),
      .rd_addr (s1_codes[j*NPLANES +: NPLANES]),
      .rd_data (out_data[j*DW +: DW])
    );
  end
endmodule

// File: rtl/lutdq_chk.sv
module lutdq_chk #(
  parameter int OW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data,
  input logic          tbl_we,
  input logic          tbl_ready
);
  assert_hold_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  assert_hold_data_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  assert_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  assert_no_write_in_flight_R7: assert property (@(posedge clk) disable iff (rst)
    tbl_ready |-> !out_valid);

  assert_write_blocks_input_R8: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> !in_ready);

  assert_drop_after_handshake_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(out_ready));
endmodule

bind twolvl_dequant lutdq_chk #(.OW(GROUP*DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .tbl_we    (tbl_we),
  .tbl_ready (tbl_ready)
);

// File: tb/sim_twolvl_dequant.sv
`timescale 1ns/1ps
module sim_twolvl_dequant;
  localparam int NP = 4;
  localparam int G  = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tbl_we = 1'b0;
  logic [NP-1:0] tbl_addr = '0;
  logic [DW-1:0] tbl_data = '0;
  logic tbl_ready;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [NP*G-1:0] in_planes = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [G*DW-1:0] out_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] tab [1<<NP];
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  twolvl_dequant #(.NPLANES(NP), .GROUP(G), .DW(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [G*DW-1:0] expect_out(input logic [NP*G-1:0] pat);
    logic [G*DW-1:0] r;
    for (int j = 0; j < G; j++) begin
      int q = 0;
      for (int b = 0; b < NP; b++) q += int'(pat[b*G+j]) << b;
      r[j*DW +: DW] = tab[q];
    end
    return r;
  endfunction

  function automatic logic [NP*G-1:0] pat_of(input int k, input int mode);
    if (mode == 0) return (NP*G)'(k);
    return (NP*G)'(k * 40503 + 11);
  endfunction

  task automatic step_lfsr();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic write_entry(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = NP'(a); tbl_data = d;
    #1;
    while (!tbl_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_table(input int scale, input int zp);
    for (int q = 0; q < (1 << NP); q++) begin
      int v = scale * (q - zp);
      tab[q] = v[DW-1:0];
      write_entry(q, tab[q]);
    end
  endtask

  // Send one group and collect its output with out_ready high.
  task automatic xfer(input logic [NP*G-1:0] pat, output logic [G*DW-1:0] d);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_planes = pat;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    while (!out_valid) begin @(negedge clk); #1; end
    d = out_data;
  endtask

  task automatic run_stream(input int n, input int mode);
    int sent = 0;
    int got = 0;
    bit fired = 1'b0;
    bit held = 1'b0;
    logic [G*DW-1:0] held_d = '0;
    while (got < n) begin
      @(negedge clk);
      step_lfsr();
      if (held) begin
        chk(out_valid && out_data == held_d, "R6", {63'd0, out_valid} ^ 64'(out_data), 64'(held_d));
        held = 1'b0;
      end
      if (fired) begin in_valid = 1'b0; fired = 1'b0; end
      out_ready = (mode == 0) ? 1'b1 : lf[0];
      if (!in_valid && sent < n && (mode == 0 || lf[3] || lf[7])) begin
        in_valid = 1'b1;
        in_planes = pat_of(sent, mode);
      end
      #1;
      if (in_valid && in_ready) begin sent++; fired = 1'b1; end
      if (out_valid && out_ready) begin
        logic [G*DW-1:0] e = expect_out(pat_of(got, mode));
        chk(out_data == e, "R2 R3 R9", 64'(out_data), 64'(e));
        got++;
      end else if (out_valid) begin
        chk(!in_ready, "R6 in_ready", 64'(in_ready), 64'd0);
        held = 1'b1; held_d = out_data;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [G*DW-1:0] d;
    logic [G*DW-1:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1: reset state
    chk(!out_valid, "R1 out_valid", 64'(out_valid), 64'd0);
    chk(in_ready, "R1 in_ready", 64'(in_ready), 64'd1);
    chk(tbl_ready, "R1 tbl_ready", 64'(tbl_ready), 64'd1);

    // R4: table load, then exhaustive sweep R2 R3 R5 (full rate)
    load_table(3, 5);
    run_stream(1 << (NP*G), 0);

    // R5: latency of a single group
    @(negedge clk);
    in_valid = 1'b1; in_planes = 16'h1234;
    #1;
    chk(in_ready, "R5 accept", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    chk(!out_valid, "R5 not yet", 64'(out_valid), 64'd0);
    @(negedge clk);
    #1;
    e = expect_out(16'h1234);
    chk(out_valid && out_data == e, "R5 R3 after two edges", 64'(out_data), 64'(e));

    // New table with negative values, stalls and gaps (R4 R6 R9)
    load_table(-1201, 9);
    run_stream(3000, 1);

    // R7: write while a group sits in the output register is refused
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_planes = 16'h0F0F;   // all elements code 5
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 4'd5; tbl_data = 16'hDEAD;
    #1;
    chk(!tbl_ready, "R7 tbl_ready low in flight", 64'(tbl_ready), 64'd0);
    chk(!in_ready, "R8 in_ready low under write", 64'(in_ready), 64'd0);
    @(negedge clk);
    tbl_we = 1'b0;
    out_ready = 1'b1;
    #1;
    e = expect_out(16'h0F0F);
    chk(out_valid && out_data == e, "R7 stalled group intact", 64'(out_data), 64'(e));
    xfer(16'h0F0F, d);
    chk(d == e, "R7 refused write left entry", 64'(d), 64'(e));

    // R8: pending write drains a stalled group, then lands (R4)
    out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_planes = 16'h00F0;   // all elements code 2
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    out_ready = 1'b1;
    tab[5] = 16'h1234;
    write_entry(5, 16'h1234);
    xfer(16'h0F0F, d);
    chk(d == {4{16'h1234}}, "R8 R4 write after drain", 64'(d), {4{16'h1234}});
    xfer(16'h0FF0, d);                       // codes 6, all lanes
    e = expect_out(16'h0FF0);
    chk(d == e, "R4 other entries kept", 64'(d), 64'(e));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule